// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block adds automatic hardware handshaking to one UART channel. On the receive side it drives the active-low RTS pin from the receive FIFO fill level. It compares that level against a halt point and a resume point, which together form a hysteresis band. Both points come from a packed threshold byte. When that byte is all zero, fallback levels supplied by the FIFO trigger logic are used instead.

On the transmit side it brings the active-low CTS pin into the clock domain and produces a transmit-permit signal. The serial transmitter consults this signal before it starts a character. While a character is in flight, the permit is re-evaluated only at the middle of the last stop bit. Any change on the synchronised CTS line also sets a sticky change flag, which the host clears by reading status.

The serial shifter, the FIFOs and the register interface live outside this block. All of its outputs are registered.

Top module: `uart_autoflow`

## Requirements
- R1: While `rst` is high, the block holds `rts_n` at 0 (asserted), `tx_permit` at 0 and `cts_chg_flag` at 0 from the next rising edge on.
- R2: The halt level is `thr_reg[3:0]` times 4 and the resume level is `thr_reg[7:4]` times 4. With auto-RTS enabled, `rts_n` goes to 1 on the rising edge after `rx_level` is at or above the halt level.
- R3: When the halt level is greater than the resume level, the following holds. A level strictly between the two leaves `rts_n` unchanged. A level at or below the resume level drives `rts_n` to 0 on the next edge.
- R4: When `thr_reg` is zero, `fb_halt_lvl` and `fb_resume_lvl` replace the halt and resume levels.
- R5: When the halt level is not greater than the resume level, `rts_n` is 0 exactly when `rx_level` was below the halt level on the previous edge, with no hysteresis.
- R6: With `rts_auto_en` low, `rts_n` is 0 on the next edge, whatever the level.
- R7: `cts_n` passes through a chain of `SYNC_STAGES` flops. With auto-CTS enabled and `tx_busy` low, `tx_permit` takes the value of `!cts_n` on the third rising edge after `cts_n` changes (default depth).
- R8: While `tx_busy` is high, `tx_permit` changes only on the edge that samples `tx_stop_mid` high. On that edge it loads the synchronised CTS-active value.
- R9: With `cts_auto_en` low, `tx_permit` is 1 on the next edge.
- R10: `cts_chg_flag` rises on the same edge as a synchronised CTS change would update `tx_permit`. It stays high until an edge samples `status_rd` high with no new change. A change wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_auto_en | input | 1 | Enables automatic RTS |
| cts_auto_en | input | 1 | Enables automatic CTS gating |
| rx_level | input | LVL_W (7) | Receive FIFO fill level, 0 to FIFO_DEPTH |
| thr_reg | input | 8 | [3:0] halt field, [7:4] resume field, units of 4 characters |
| fb_halt_lvl | input | LVL_W (7) | Fallback halt level from FIFO trigger setting |
| fb_resume_lvl | input | LVL_W (7) | Fallback resume level from FIFO trigger setting |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_stop_mid | input | 1 | One-cycle pulse at the middle of the last stop bit |
| status_rd | input | 1 | Host status read, clears the change flag |
| rts_n | output | 1 | Active-low request-to-send pin |
| tx_permit | output | 1 | Transmitter may start the next character |
| cts_chg_flag | output | 1 | Sticky CTS change indication |

## Verification
The checker assumes a few things about the inputs. The receive level never exceeds the FIFO depth. The fallback halt level is no larger than the depth, so a full FIFO always halts the sender. The stop-bit pulse arrives only while the transmitter reports busy. The stimulus drives levels only in the range 0 to 64, keeps fallback levels at 16 and 4, and raises `tx_stop_mid` for a single cycle with `tx_busy` held high. CTS changes are spaced several cycles apart so that each one clears the synchroniser before the next check.

// File: rtl/uart_autoflow_pkg.sv
package uart_autoflow_pkg;
  localparam int AF_FIELD_W   = 4;
  localparam int AF_THR_W     = 2 * AF_FIELD_W;
  localparam int AF_UNIT_SHIFT = 2;

  typedef enum logic [1:0] {
    RTS_CMD_HOLD   = 2'd0,
    RTS_CMD_HALT   = 2'd1,
    RTS_CMD_RESUME = 2'd2
  } rts_cmd_e;
endpackage

// File: rtl/uart_autoflow_thr.sv
module uart_autoflow_thr
  import uart_autoflow_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic [AF_THR_W-1:0] thr_reg,
  input  logic [LVL_W-1:0]    fb_halt_lvl,
  input  logic [LVL_W-1:0]    fb_resume_lvl,
  output logic [LVL_W-1:0]    halt_lvl,
  output logic [LVL_W-1:0]    resume_lvl,
  output logic                hyst_ok
);
  logic [LVL_W-1:0] halt_raw;
  logic [LVL_W-1:0] resume_raw;
  logic             use_fb;

  // Field value scaled to characters (units of four).
  assign halt_raw   = LVL_W'(thr_reg[AF_FIELD_W-1:0]) << AF_UNIT_SHIFT;
  assign resume_raw = LVL_W'(thr_reg[AF_THR_W-1:AF_FIELD_W]) << AF_UNIT_SHIFT;
  assign use_fb     = (thr_reg == '0);

  always_comb begin
    if (use_fb) begin
      halt_lvl   = fb_halt_lvl;
      resume_lvl = fb_resume_lvl;
    end else begin
      halt_lvl   = halt_raw;
      resume_lvl = resume_raw;
    end
    hyst_ok = (halt_lvl > resume_lvl);
  end
endmodule

// File: rtl/uart_autoflow_rts.sv
module uart_autoflow_rts
  import uart_autoflow_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic             hyst_ok,
  output logic             rts_n
);
  rts_cmd_e cmd;
  logic     rts_n_q;

  always_comb begin
    if (level >= halt_lvl)
      cmd = RTS_CMD_HALT;
    else if (!hyst_ok)
      cmd = RTS_CMD_RESUME;          // no band: below halt means resume
    else if (level <= resume_lvl)
      cmd = RTS_CMD_RESUME;
    else
      cmd = RTS_CMD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n_q <= 1'b0;
    end else if (!enable) begin
      rts_n_q <= 1'b0;
    end else begin
      case (cmd)
        RTS_CMD_HALT:   rts_n_q <= 1'b1;
        RTS_CMD_RESUME: rts_n_q <= 1'b0;
        default:        rts_n_q <= rts_n_q;
      endcase
    end
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/uart_autoflow_sync.sv
module uart_autoflow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_autoflow_cts.sv
module uart_autoflow_cts #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic cts_n,
  input  logic tx_busy,
  input  logic tx_stop_mid,
  input  logic status_rd,
  output logic tx_permit,
  output logic cts_chg_flag
);
  logic cts_sync_n;
  logic cts_prev_n;
  logic cts_change;
  logic permit_q;
  logic flag_q;

  uart_autoflow_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (cts_n),
    .q  (cts_sync_n)
  );

  assign cts_change = (cts_sync_n != cts_prev_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_prev_n <= 1'b1;
      flag_q     <= 1'b0;
      permit_q   <= 1'b0;
    end else begin
      cts_prev_n <= cts_sync_n;
      if (cts_change)     flag_q <= 1'b1;
      else if (status_rd) flag_q <= 1'b0;
      if (!enable)                    permit_q <= 1'b1;
      else if (!tx_busy || tx_stop_mid) permit_q <= ~cts_sync_n;
    end
  end

  assign tx_permit    = permit_q;
  assign cts_chg_flag = flag_q;
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import uart_autoflow_pkg::*;
#(
  parameter  int FIFO_DEPTH  = 64,
  parameter  int SYNC_STAGES = 2,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rts_auto_en,
  input  logic                cts_auto_en,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [AF_THR_W-1:0] thr_reg,
  input  logic [LVL_W-1:0]    fb_halt_lvl,
  input  logic [LVL_W-1:0]    fb_resume_lvl,
  input  logic                cts_n,
  input  logic                tx_busy,
  input  logic                tx_stop_mid,
  input  logic                status_rd,
  output logic                rts_n,
  output logic                tx_permit,
  output logic                cts_chg_flag
);
  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;
  logic             hyst_ok;

  uart_autoflow_thr #(.LVL_W(LVL_W)) u_thr (
    .thr_reg      (thr_reg),
    .fb_halt_lvl  (fb_halt_lvl),
    .fb_resume_lvl(fb_resume_lvl),
    .halt_lvl     (halt_lvl),
    .resume_lvl   (resume_lvl),
    .hyst_ok      (hyst_ok)
  );

  uart_autoflow_rts #(.LVL_W(LVL_W)) u_rts (
    .clk       (clk),
    .rst       (rst),
    .enable    (rts_auto_en),
    .level     (rx_level),
    .halt_lvl  (halt_lvl),
    .resume_lvl(resume_lvl),
    .hyst_ok   (hyst_ok),
    .rts_n     (rts_n)
  );

  uart_autoflow_cts #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk         (clk),
    .rst         (rst),
    .enable      (cts_auto_en),
    .cts_n       (cts_n),
    .tx_busy     (tx_busy),
    .tx_stop_mid (tx_stop_mid),
    .status_rd   (status_rd),
    .tx_permit   (tx_permit),
    .cts_chg_flag(cts_chg_flag)
  );
endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk #(
  parameter  int FIFO_DEPTH = 64,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rts_auto_en,
  input logic             cts_auto_en,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_busy,
  input logic             tx_stop_mid,
  input logic             status_rd,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             cts_chg_flag
);
  assert_level_range_R2: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LVL_W'(FIFO_DEPTH));

  assert_full_halts_R2: assert property (@(posedge clk) disable iff (rst)
    (rts_auto_en && rx_level == LVL_W'(FIFO_DEPTH)) |=> rts_n);

  assert_rts_forced_R6: assert property (@(posedge clk) disable iff (rst)
    !rts_auto_en |=> !rts_n);

  assert_permit_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cts_auto_en && tx_busy && !tx_stop_mid) |=> $stable(tx_permit));

  assert_pulse_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    tx_stop_mid |-> tx_busy);

  assert_permit_free_R9: assert property (@(posedge clk) disable iff (rst)
    !cts_auto_en |=> tx_permit);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (cts_chg_flag && !status_rd) |=> cts_chg_flag);
endmodule

bind uart_autoflow uart_autoflow_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rts_auto_en (rts_auto_en),
  .cts_auto_en (cts_auto_en),
  .rx_level    (rx_level),
  .tx_busy     (tx_busy),
  .tx_stop_mid (tx_stop_mid),
  .status_rd   (status_rd),
  .rts_n       (rts_n),
  .tx_permit   (tx_permit),
  .cts_chg_flag(cts_chg_flag)
);

// File: tb/uart_autoflow_tb.sv
module uart_autoflow_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 7;

  logic             clk = 1'b0;
  logic             rst;
  logic             rts_auto_en;
  logic             cts_auto_en;
  logic [LVL_W-1:0] rx_level;
  logic [7:0]       thr_reg;
  logic [LVL_W-1:0] fb_halt_lvl;
  logic [LVL_W-1:0] fb_resume_lvl;
  logic             cts_n;
  logic             tx_busy;
  logic             tx_stop_mid;
  logic             status_rd;
  logic             rts_n;
  logic             tx_permit;
  logic             cts_chg_flag;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_autoflow u_dut (
    .clk          (clk),
    .rst          (rst),
    .rts_auto_en  (rts_auto_en),
    .cts_auto_en  (cts_auto_en),
    .rx_level     (rx_level),
    .thr_reg      (thr_reg),
    .fb_halt_lvl  (fb_halt_lvl),
    .fb_resume_lvl(fb_resume_lvl),
    .cts_n        (cts_n),
    .tx_busy      (tx_busy),
    .tx_stop_mid  (tx_stop_mid),
    .status_rd    (status_rd),
    .rts_n        (rts_n),
    .tx_permit    (tx_permit),
    .cts_chg_flag (cts_chg_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic t_reset();
    step(3);
    chk(rts_n, 1'b0, "R1 rts_n in reset");
    chk(tx_permit, 1'b0, "R1 tx_permit in reset");
    chk(cts_chg_flag, 1'b0, "R1 flag in reset");
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_hysteresis();
    thr_reg = 8'h25;                       // halt 20, resume 8
    rx_level = 7'd19; step(1); chk(rts_n, 1'b0, "R2 below halt");
    rx_level = 7'd20; step(1); chk(rts_n, 1'b1, "R2 at halt");
    rx_level = 7'd12; step(1); chk(rts_n, 1'b1, "R3 inside band keeps halted");
    rx_level = 7'd9;  step(1); chk(rts_n, 1'b1, "R3 just above resume");
    rx_level = 7'd8;  step(1); chk(rts_n, 1'b0, "R3 at resume");
    rx_level = 7'd15; step(1); chk(rts_n, 1'b0, "R3 inside band keeps asserted");
    rx_level = 7'd0;  step(1);
  endtask

  task automatic t_fallback();
    thr_reg = 8'h00;                       // fallback halt 16, resume 4
    rx_level = 7'd15; step(1); chk(rts_n, 1'b0, "R4 below fallback halt");
    rx_level = 7'd16; step(1); chk(rts_n, 1'b1, "R4 at fallback halt");
    rx_level = 7'd5;  step(1); chk(rts_n, 1'b1, "R4 above fallback resume");
    rx_level = 7'd4;  step(1); chk(rts_n, 1'b0, "R4 at fallback resume");
  endtask

  task automatic t_no_band();
    thr_reg = 8'h63;                       // halt 12, resume 24
    rx_level = 7'd0;  step(1); chk(rts_n, 1'b0, "R5 empty");
    rx_level = 7'd12; step(1); chk(rts_n, 1'b1, "R5 at halt");
    rx_level = 7'd11; step(1); chk(rts_n, 1'b0, "R5 one below halt");
    rx_level = 7'd13; step(1); chk(rts_n, 1'b1, "R5 above halt");
    rx_level = 7'd0;  step(1);
  endtask

  task automatic t_rts_off();
    thr_reg = 8'h25;
    rts_auto_en = 1'b0; rx_level = 7'd64; step(1);
    chk(rts_n, 1'b0, "R6 disabled with full FIFO");
    rts_auto_en = 1'b1; step(1);
    chk(rts_n, 1'b1, "R6 re-enabled with full FIFO");
    rx_level = 7'd0; step(1);
  endtask

  task automatic t_cts_idle();
    chk(tx_permit, 1'b0, "R7 CTS inactive while idle");
    cts_n = 1'b0;
    step(2); chk(tx_permit, 1'b0, "R7 still inside synchroniser");
    chk(cts_chg_flag, 1'b0, "R10 flag not yet set");
    step(1); chk(tx_permit, 1'b1, "R7 permit on third edge");
    chk(cts_chg_flag, 1'b1, "R10 flag set with permit");
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    chk(cts_chg_flag, 1'b0, "R10 cleared by status read");
  endtask

  task automatic t_cts_busy();
    tx_busy = 1'b1;
    cts_n = 1'b1; step(4);
    chk(tx_permit, 1'b1, "R8 busy holds permit");
    tx_stop_mid = 1'b1; step(1); tx_stop_mid = 1'b0;
    chk(tx_permit, 1'b0, "R8 stop-bit sample stops next char");
    cts_n = 1'b0; step(4);
    chk(tx_permit, 1'b0, "R8 busy holds denial");
    tx_stop_mid = 1'b1; step(1); tx_stop_mid = 1'b0;
    chk(tx_permit, 1'b1, "R8 stop-bit sample allows next char");
    cts_n = 1'b1; step(4);
    chk(tx_permit, 1'b1, "R8 late CTS drop ignored while busy");
    tx_busy = 1'b0; step(1);
    chk(tx_permit, 1'b0, "R7 idle follows CTS again");
    status_rd = 1'b1; step(1); status_rd = 1'b0;
  endtask

  task automatic t_flag();
    chk(cts_chg_flag, 1'b0, "R10 flag clear before test");
    cts_n = 1'b0; step(2);
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    chk(cts_chg_flag, 1'b1, "R10 set wins over clear");
    step(5);
    chk(cts_chg_flag, 1'b1, "R10 sticky without read");
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    chk(cts_chg_flag, 1'b0, "R10 read clears");
    step(3);
    chk(cts_chg_flag, 1'b0, "R10 no change no flag");
  endtask

  task automatic t_cts_off();
    cts_auto_en = 1'b0; cts_n = 1'b1; tx_busy = 1'b1; step(1);
    chk(tx_permit, 1'b1, "R9 disabled permits despite CTS inactive");
    tx_busy = 1'b0; step(4);
    chk(tx_permit, 1'b1, "R9 disabled stays permitted");
  endtask

  initial begin
    rst = 1'b1; rts_auto_en = 1'b1; cts_auto_en = 1'b1;
    rx_level = '0; thr_reg = 8'h00;
    fb_halt_lvl = 7'd16; fb_resume_lvl = 7'd4;
    cts_n = 1'b1; tx_busy = 1'b0; tx_stop_mid = 1'b0; status_rd = 1'b0;
    t_reset();
    t_hysteresis();
    t_fallback();
    t_no_band();
    t_rts_off();
    t_cts_idle();
    t_cts_busy();
    t_flag();
    t_cts_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule